// File: doc/BRIEF.md
# Receive Word Label Filter and FIFO

This block sits behind a serial receive decoder for 32-bit avionics data words. On each end-of-word strobe it decides whether to keep the word. Two checks can be switched on. One is a label check: the first eight bits of the word are compared against 16 stored label values at once. The other is a source/destination check: bits 9 and 10 are compared with two programmed values. Words that pass every enabled check go into a 32-entry receive FIFO. A host reads each word as two 16-bit halves. A byte-select input picks the half, and reading the second half removes the word from the FIFO.

A six-bit control register is written from the same 16-bit bus. One of its bits opens a label-memory session. While the session is open, the host writes the 16 labels in order, or reads them back in order, and incoming words are not stored. Another control bit picks between two bit-to-bus layouts for the stored word. Data-ready, half-full and full flags are registered outputs. When the FIFO is full, a newly accepted word replaces the most recent entry, so the oldest entries are kept.

Top module: `arx_label_filter_rx`

## Requirements
- R1: While `rst` is high, and after it is released, `data_rdy`, `half_full`, `full` and `rd_data` are 0. All control bits and all stored labels are also 0.
- R2: A pulse on `ctl_wr` loads `bus_wdata[5:0]` into the control register. The bits are: bit0 label-session, bit1 label check enable, bit2 source/destination check enable, bit3 value that word bit 9 must match, bit4 value that word bit 10 must match, bit5 unscramble. With label check enabled, a word is stored only if `word_in[7:0]` (word bits 1-8) equals one of the 16 stored labels. The value 0x00 is matched like any other value.
- R3: With the source/destination check enabled, a word is stored only if `word_in[8]` equals control bit3 and `word_in[9]` equals control bit4. A word is stored only when every enabled check passes. A disabled check always passes.
- R4: A control write that changes bit0 from 0 to 1 opens a label session. The next 16 `lbl_wr` pulses write `bus_wdata[7:0]` into label locations 1 to 16 in order. Further `lbl_wr` pulses in that session are ignored.
- R5: In the same session, the next 16 `rd_stb` pulses return labels 1 to 16 in order on `rd_data[7:0]`, with `rd_data[15:8]` = 0. Later reads leave `rd_data` unchanged.
- R6: While control bit0 is 1, words on `word_in` are never stored.
- R7: The FIFO holds 32 words. When it is full and a word is accepted without a pop, that word replaces entry 32 and the first 31 entries are kept.
- R8: One clock after the FIFO count changes, `data_rdy` shows count > 0, `half_full` shows count ≥ 16 and `full` shows count = 32.
- R9: A normal-mode `rd_stb` with `byte_sel` = 0 puts the first half of the head word on `rd_data` one clock later and does not pop. With `byte_sel` = 1 it puts the second half there and pops the word.
- R10: With control bit5 = 1, the first half is word bits 16..1 (`rd_data[i]` = bit i+1). The second half is bits 32..17.
- R11: With control bit5 = 0, the first half, from `rd_data[15]` down to `rd_data[0]`, is word bits 13, 12, 11, 10, 9, 31, 30, 32, 1, 2, 3, 4, 5, 6, 7, 8. The second half is bits 29 down to 14.
- R12: A normal-mode `rd_stb` on an empty FIFO leaves `rd_data` and the flags unchanged.
- R13: An accepted word and a popping read in the same clock both take effect: the count is unchanged and the new word ends up behind the remaining entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| word_vld | input | 1 | End-of-word strobe from the decoder |
| word_in | input | 32 | Received word, bit 1 at index 0 |
| ctl_wr | input | 1 | Control register write strobe |
| lbl_wr | input | 1 | Label write strobe (label session only) |
| bus_wdata | input | 16 | Host write data |
| rd_stb | input | 1 | Host read strobe |
| byte_sel | input | 1 | Half select for FIFO reads |
| rd_data | output | 16 | Registered read data |
| data_rdy | output | 1 | FIFO not empty |
| half_full | output | 1 | FIFO holds at least 16 words |
| full | output | 1 | FIFO holds 32 words |

## Verification
The hardest case to reach from the ports is the overwrite of entry 32. It needs 33 accepted words with no pop in between, followed by a full drain that shows entries 1 to 31 unchanged and the last word in slot 32. The stimulus reaches it by switching both checks off and pushing on back-to-back clocks. It also watches `half_full` and `full` at the 15/16 and 31/32 boundaries while filling and while draining. A second hard case is a push and a popping read on the same edge. It is set up from a single stored word, so that the unchanged flags and the order of the next read show both actions took effect.

// File: rtl/arx_pkg.sv
package arx_pkg;
  localparam int WORD_W = 32;
  localparam int BUS_W  = 16;
  localparam int LBL_W  = 8;
  localparam int CTL_W  = 6;

  typedef struct packed {
    logic unscr;
    logic sd_b10;
    logic sd_b9;
    logic sd_en;
    logic lbl_en;
    logic lbl_mode;
  } arx_ctl_t;
endpackage

// File: rtl/arx_label_cam.sv
module arx_label_cam #(
  parameter int N_LBL = 16,
  parameter int LBL_W = 8,
  localparam int IW = $clog2(N_LBL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IW-1:0]    waddr,
  input  logic [LBL_W-1:0] wdata,
  input  logic [LBL_W-1:0] key,
  input  logic [IW-1:0]    raddr,
  output logic             hit,
  output logic [LBL_W-1:0] rdata
);
  logic [LBL_W-1:0] tbl [N_LBL];
  logic [N_LBL-1:0] match_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_LBL; i++) tbl[i] <= '0;
    end else if (we) begin
      tbl[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < N_LBL; g++) begin : g_cmp
    assign match_vec[g] = (tbl[g] == key);
  end

  assign hit   = |match_vec;
  assign rdata = tbl[raddr];
endmodule

// File: rtl/arx_rx_fifo.sv
module arx_rx_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  head,
  output logic [CW-1:0] cnt,
  output logic          nonempty_q,
  output logic          half_q,
  output logic          full_q
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, wa;
  logic          pop_ok, ovw, adv;
  logic [CW-1:0] cnt_nxt;

  assign pop_ok = pop && (cnt != '0);
  assign ovw    = push && full_q && !pop_ok;
  assign adv    = push && !ovw;
  assign wa     = ovw ? (wr_ptr - 1'b1) : wr_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wa] <= din;
  end

  assign head = mem[rd_ptr];

  always_comb begin
    case ({adv, pop_ok})
      2'b10:   cnt_nxt = cnt + 1'b1;
      2'b01:   cnt_nxt = cnt - 1'b1;
      default: cnt_nxt = cnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      cnt        <= '0;
      nonempty_q <= 1'b0;
      half_q     <= 1'b0;
      full_q     <= 1'b0;
    end else begin
      if (adv)    wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok) rd_ptr <= rd_ptr + 1'b1;
      cnt        <= cnt_nxt;
      nonempty_q <= (cnt_nxt != '0);
      half_q     <= (cnt_nxt >= HALF_CNT);
      full_q     <= (cnt_nxt == FULL_CNT);
    end
  end
endmodule

// File: rtl/arx_bus_map.sv
module arx_bus_map (
  input  logic [31:0] word,
  input  logic        unscr,
  output logic [15:0] lo,
  output logic [15:0] hi
);
  logic [15:0] scr_lo, scr_hi;

  assign scr_lo[15:11] = word[12:8];
  assign scr_lo[10]    = word[30];
  assign scr_lo[9]     = word[29];
  assign scr_lo[8]     = word[31];
  for (genvar k = 0; k < 8; k++) begin : g_lbl_rev
    assign scr_lo[7-k] = word[k];
  end
  assign scr_hi = word[28:13];

  assign lo = unscr ? word[15:0]  : scr_lo;
  assign hi = unscr ? word[31:16] : scr_hi;
endmodule

// File: rtl/arx_label_filter_rx.sv
module arx_label_filter_rx
  import arx_pkg::*;
#(
  parameter int FIFO_DEPTH = 32,
  parameter int N_LBL      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word_in,
  input  logic              ctl_wr,
  input  logic              lbl_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              rd_stb,
  input  logic              byte_sel,
  output logic [BUS_W-1:0]  rd_data,
  output logic              data_rdy,
  output logic              half_full,
  output logic              full
);
  localparam int IW = $clog2(N_LBL);
  localparam int CW = $clog2(FIFO_DEPTH) + 1;
  localparam logic [IW:0] LBL_END = (IW+1)'(N_LBL);

  arx_ctl_t          ctl_q, ctl_d;
  logic [IW:0]       widx, ridx;
  logic              lbl_we, lbl_re, lbl_hit, sd_ok, lbl_ok, accept, pop;
  logic [LBL_W-1:0]  lbl_rdata;
  logic [WORD_W-1:0] head;
  logic [CW-1:0]     fifo_cnt;
  logic [BUS_W-1:0]  half_lo, half_hi;
  logic              unused_bus;

  assign ctl_d      = arx_ctl_t'(bus_wdata[CTL_W-1:0]);
  assign unused_bus = ^bus_wdata[BUS_W-1:LBL_W];

  // control register and label session indices
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      widx  <= '0;
      ridx  <= '0;
    end else begin
      if (ctl_wr) begin
        ctl_q <= ctl_d;
        if (ctl_d.lbl_mode && !ctl_q.lbl_mode) begin
          widx <= '0;
          ridx <= '0;
        end
      end else if (lbl_we) begin
        widx <= widx + 1'b1;
      end
      if (lbl_re && !ctl_wr) ridx <= ridx + 1'b1;
    end
  end

  assign lbl_we = ctl_q.lbl_mode && lbl_wr && !ctl_wr && (widx < LBL_END);
  assign lbl_re = ctl_q.lbl_mode && rd_stb && (ridx < LBL_END);

  arx_label_cam #(.N_LBL(N_LBL), .LBL_W(LBL_W)) cam_i (
    .clk   (clk),
    .rst   (rst),
    .we    (lbl_we),
    .waddr (widx[IW-1:0]),
    .wdata (bus_wdata[LBL_W-1:0]),
    .key   (word_in[LBL_W-1:0]),
    .raddr (ridx[IW-1:0]),
    .hit   (lbl_hit),
    .rdata (lbl_rdata)
  );

  assign lbl_ok = !ctl_q.lbl_en || lbl_hit;
  assign sd_ok  = !ctl_q.sd_en ||
                  ((word_in[8] == ctl_q.sd_b9) && (word_in[9] == ctl_q.sd_b10));
  assign accept = word_vld && !ctl_q.lbl_mode && lbl_ok && sd_ok;
  assign pop    = !ctl_q.lbl_mode && rd_stb && byte_sel;

  arx_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) fifo_i (
    .clk        (clk),
    .rst        (rst),
    .push       (accept),
    .pop        (pop),
    .din        (word_in),
    .head       (head),
    .cnt        (fifo_cnt),
    .nonempty_q (data_rdy),
    .half_q     (half_full),
    .full_q     (full)
  );

  arx_bus_map map_i (
    .word  (head),
    .unscr (ctl_q.unscr),
    .lo    (half_lo),
    .hi    (half_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (lbl_re) begin
      rd_data <= {{(BUS_W-LBL_W){1'b0}}, lbl_rdata};
    end else if (!ctl_q.lbl_mode && rd_stb && (fifo_cnt != '0)) begin
      rd_data <= byte_sel ? half_hi : half_lo;
    end
  end
endmodule

// File: rtl/arx_label_filter_rx_chk.sv
module arx_label_filter_rx_chk #(
  parameter int DEPTH = 32,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             word_vld,
  input logic             rd_stb,
  input logic             byte_sel,
  input logic [15:0]      rd_data,
  input logic             data_rdy,
  input logic             half_full,
  input logic             full,
  input logic             lbl_mode,
  input logic [CNT_W-1:0] fifo_cnt
);
  AST_FULL_HAS_HALF: assert property (@(posedge clk) disable iff (rst)
    full |-> half_full); // R8
  AST_HALF_HAS_RDY: assert property (@(posedge clk) disable iff (rst)
    half_full |-> data_rdy); // R8
  AST_FULL_MATCHES_CNT: assert property (@(posedge clk) disable iff (rst)
    full |-> (fifo_cnt == CNT_W'(DEPTH))); // R8
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    fifo_cnt <= CNT_W'(DEPTH)); // R7
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (full && !(rd_stb && byte_sel)) |=> full); // R7
  AST_SESSION_NO_STORE: assert property (@(posedge clk) disable iff (rst)
    lbl_mode |=> $stable(fifo_cnt)); // R6
  AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !lbl_mode && fifo_cnt == '0) |=> $stable(rd_data)); // R12
  AST_POP_DECR: assert property (@(posedge clk) disable iff (rst)
    (!lbl_mode && rd_stb && byte_sel && fifo_cnt != '0 && !word_vld)
      |=> (fifo_cnt == $past(fifo_cnt) - 1'b1)); // R9
endmodule

bind arx_label_filter_rx arx_label_filter_rx_chk #(
  .DEPTH (FIFO_DEPTH),
  .CNT_W (CW)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .word_vld  (word_vld),
  .rd_stb    (rd_stb),
  .byte_sel  (byte_sel),
  .rd_data   (rd_data),
  .data_rdy  (data_rdy),
  .half_full (half_full),
  .full      (full),
  .lbl_mode  (ctl_q.lbl_mode),
  .fifo_cnt  (fifo_cnt)
);

// File: tb/arx_label_filter_rx_tb.sv
module arx_label_filter_rx_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        word_vld = 1'b0;
  logic [31:0] word_in = '0;
  logic        ctl_wr = 1'b0;
  logic        lbl_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic        rd_stb = 1'b0;
  logic        byte_sel = 1'b0;
  logic [15:0] rd_data;
  logic        data_rdy, half_full, full;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  arx_label_filter_rx dut_i (
    .clk(clk), .rst(rst), .word_vld(word_vld), .word_in(word_in),
    .ctl_wr(ctl_wr), .lbl_wr(lbl_wr), .bus_wdata(bus_wdata),
    .rd_stb(rd_stb), .byte_sel(byte_sel), .rd_data(rd_data),
    .data_rdy(data_rdy), .half_full(half_full), .full(full)
  );

  typedef struct packed {
    logic        keep;
    logic [5:0]  cfg;
    logic [31:0] word;
  } vec_t;

  // cfg: bit5 unscramble, bit4 b10, bit3 b9, bit2 sd check, bit1 label check
  localparam vec_t VECS [10] = '{
    '{1'b1, 6'b100000, 32'h1234_5678},
    '{1'b1, 6'b000000, 32'hA5C3_0F96},
    '{1'b1, 6'b000010, 32'hDEAD_BE00},
    '{1'b0, 6'b000010, 32'h1111_1101},
    '{1'b1, 6'b100010, 32'h8000_03A5},
    '{1'b1, 6'b001100, 32'h7654_3DFF},
    '{1'b0, 6'b001100, 32'h7654_3EFF},
    '{1'b1, 6'b010110, 32'h0F0F_F22C},
    '{1'b0, 6'b010110, 32'h0F0F_F12C},
    '{1'b0, 6'b010110, 32'h0F0F_F22D}
  };

  function automatic logic [7:0] lbl_val(int i);
    return 8'(i * 11);
  endfunction

  function automatic logic abit(logic [31:0] w, int n);
    return w[n-1];
  endfunction

  function automatic logic [15:0] exp_lo(logic [31:0] w, logic unscr);
    logic [15:0] r;
    if (unscr) begin
      for (int i = 0; i < 16; i++) r[i] = abit(w, i + 1);
    end else begin
      r[15] = abit(w, 13); r[14] = abit(w, 12); r[13] = abit(w, 11);
      r[12] = abit(w, 10); r[11] = abit(w, 9);  r[10] = abit(w, 31);
      r[9]  = abit(w, 30); r[8]  = abit(w, 32);
      for (int k = 0; k < 8; k++) r[7-k] = abit(w, k + 1);
    end
    return r;
  endfunction

  function automatic logic [15:0] exp_hi(logic [31:0] w, logic unscr);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = unscr ? abit(w, 17 + i) : abit(w, 14 + i);
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ctl_write(input logic [5:0] d);
    bus_wdata = {10'd0, d}; ctl_wr = 1'b1;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic lbl_write(input logic [7:0] d);
    bus_wdata = {8'd0, d}; lbl_wr = 1'b1;
    @(negedge clk); lbl_wr = 1'b0;
  endtask

  task automatic push(input logic [31:0] w);
    word_in = w; word_vld = 1'b1;
    @(negedge clk); word_vld = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [15:0] v);
    byte_sel = sel; rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0; v = rd_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [31:0] w;
    repeat (3) @(negedge clk);
    chk("R1 flags in reset", {29'd0, data_rdy, half_full, full}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rd_data after reset", {16'd0, rd_data}, 32'd0);
    chk("R1 flags after reset", {29'd0, data_rdy, half_full, full}, 32'd0);

    // label session: 16 loads plus one extra that must be ignored (R4)
    ctl_write(6'b000000);
    ctl_write(6'b000001);
    for (int i = 0; i < 16; i++) lbl_write(lbl_val(i));
    lbl_write(8'hFF);
    // R6: word offered in session is not stored
    push(32'h0000_0001);
    @(negedge clk);
    chk("R6 no store in label session", {31'd0, data_rdy}, 32'd0);
    ctl_write(6'b000000);
    ctl_write(6'b000001);
    for (int i = 0; i < 16; i++) begin
      rd(1'b1, v);
      chk("R5 label readback", {16'd0, v}, {24'd0, lbl_val(i)});
    end
    rd(1'b0, v);
    chk("R5 read past 16 holds", {16'd0, v}, {24'd0, lbl_val(15)});
    ctl_write(6'b000010);
    chk("R6 still empty after session", {31'd0, data_rdy}, 32'd0);
    push(32'h0000_00FF);
    @(negedge clk);
    chk("R4 extra label write ignored", {31'd0, data_rdy}, 32'd0);

    // vector table: filtering and both bus layouts (R2 R3 R10 R11)
    foreach (VECS[n]) begin
      ctl_write(VECS[n].cfg);
      push(VECS[n].word);
      chk("R2 R3 store decision", {31'd0, data_rdy}, {31'd0, VECS[n].keep});
      if (VECS[n].keep) begin
        rd(1'b0, v);
        chk(VECS[n].cfg[5] ? "R10 first half" : "R11 first half",
            {16'd0, v}, {16'd0, exp_lo(VECS[n].word, VECS[n].cfg[5])});
        rd(1'b1, v);
        chk(VECS[n].cfg[5] ? "R10 second half" : "R11 second half",
            {16'd0, v}, {16'd0, exp_hi(VECS[n].word, VECS[n].cfg[5])});
        chk("R8 empty after pop", {31'd0, data_rdy}, 32'd0);
      end
    end

    // R9: low-half reads do not pop
    ctl_write(6'b100000);
    push(32'h5555_6666);
    rd(1'b0, v); chk("R9 low half", {16'd0, v}, 32'h6666);
    rd(1'b0, v); chk("R9 low half no pop", {16'd0, v}, 32'h6666);
    chk("R9 still ready", {31'd0, data_rdy}, 32'd1);
    rd(1'b1, v); chk("R9 high half", {16'd0, v}, 32'h5555);
    chk("R9 popped", {31'd0, data_rdy}, 32'd0);

    // R13: push and pop together
    push(32'h1111_2222);
    word_in = 32'h3333_4444; word_vld = 1'b1; byte_sel = 1'b1; rd_stb = 1'b1;
    @(negedge clk); word_vld = 1'b0; rd_stb = 1'b0;
    chk("R13 pop side", {16'd0, rd_data}, 32'h1111);
    chk("R13 count kept", {31'd0, data_rdy}, 32'd1);
    rd(1'b0, v); chk("R13 push side low", {16'd0, v}, 32'h4444);
    rd(1'b1, v); chk("R13 push side high", {16'd0, v}, 32'h3333);

    // R12: reads on empty FIFO
    rd(1'b0, v); chk("R12 empty read low", {16'd0, v}, 32'h3333);
    rd(1'b1, v); chk("R12 empty read high", {16'd0, v}, 32'h3333);
    chk("R12 flags", {29'd0, data_rdy, half_full, full}, 32'd0);

    // R7/R8: fill, overflow, drain
    for (int i = 1; i <= 32; i++) begin
      push({16'hA000 + 16'(i), 16'(i)});
      if (i == 15) chk("R8 half at 15", {30'd0, half_full, full}, 32'b00);
      if (i == 16) chk("R8 half at 16", {30'd0, half_full, full}, 32'b10);
      if (i == 31) chk("R8 not full at 31", {30'd0, half_full, full}, 32'b10);
      if (i == 32) chk("R8 full at 32", {30'd0, half_full, full}, 32'b11);
    end
    push(32'hBEEF_0099);
    chk("R7 full after overflow", {31'd0, full}, 32'd1);
    for (int i = 1; i <= 32; i++) begin
      w = (i == 32) ? 32'hBEEF_0099 : {16'hA000 + 16'(i), 16'(i)};
      rd(1'b0, v); chk("R7 drain low", {16'd0, v}, {16'd0, w[15:0]});
      rd(1'b1, v); chk("R7 drain high", {16'd0, v}, {16'd0, w[31:16]});
      if (i == 1)  chk("R8 not full at 31", {31'd0, full}, 32'd0);
      if (i == 16) chk("R8 half at 16 drain", {31'd0, half_full}, 32'd1);
      if (i == 17) chk("R8 half at 15 drain", {31'd0, half_full}, 32'd0);
    end
    chk("R8 empty after drain", {29'd0, data_rdy, half_full, full}, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule